// File: doc/BRIEF.md
# AUX Request Header Formatter

This block sits between a transaction source and an AUX channel engine. It accepts one request at a time: a 4-bit request code, a 20-bit target address, a payload length and, for writes, up to sixteen payload bytes. It packs the address, code and length into a four-byte header and sends it as a byte stream. For writes the payload bytes follow the header. Requests that are too long or carry an unsupported code are turned back at once and send nothing.

After the last byte leaves, the block waits for the engine's reply status. It sorts that status into a result code, a 4-bit reply field and a received byte count, and returns them as a one-cycle result pulse. The request port then opens for the next request. Only one transaction is in flight at a time.

Top module: `aux_req_fmt`

## Requirements
- R1: Header byte 0 is address bits 7:0 and header byte 1 is address bits 15:8. Header byte 2 carries the request code in bits 7:4 and address bits 19:16 in bits 3:0. Bytes leave in order 0, 1, 2, 3.
- R2: Bits 3:0 of header byte 3 hold the payload length minus one, or 0 when the length is 0.
- R3: Bits 7:4 of header byte 3 hold a size code. It is 3 for any zero-length request, 4 for a read, and the low four bits of (4 + length) for a write. For example, length 12 gives 0 and length 16 gives 4.
- R4: A write sends 4 + length bytes: the header, then payload byte i taken from `req_payload[8i+7:8i]`. A read sends only the 4 header bytes. A zero-length write also sends only the 4 header bytes. `tx_last` is high on the final byte only.
- R5: A request with a length above 16 gives a result with code 4 (too big) one cycle after it is accepted. It puts no byte on the stream.
- R6: Bit 2 of the request code (middle-of-transaction) is ignored. With bit 2 cleared, codes 0x0 and 0x8 are writes and codes 0x1 and 0x9 are reads. Any code with bit 1 set gives a result with code 5 (invalid) one cycle after acceptance, and puts no byte on the stream.
- R7: A reply status of 1 gives result code 1 (timeout), 2 gives code 2 (flags not zero) and 3 gives code 3 (error). Each of these reports a count of 0 and a reply field of 0.
- R8: Any other status gives result code 0 (success) with the reply field equal to status bits 7:4. The count is the payload length for a write. For a read, the count is the engine's received count limited to the requested length.
- R9: `req_ready` is low from the cycle after acceptance until the result pulse. It is high again in the cycle the result is shown, so at most one transaction is outstanding.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R11: After reset, `req_ready` is high and `tx_valid` and `res_valid` are low.
- R12: `rsp_valid` has no effect unless the block is waiting for a reply. No result is produced from it in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_cmd | input | 4 | Request code |
| req_addr | input | 20 | Target address |
| req_len | input | 6 | Payload length in bytes |
| req_payload | input | 128 | Write payload, byte i in bits 8i+7:8i |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Engine takes the byte |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the transaction |
| rsp_valid | input | 1 | Engine reply status valid |
| rsp_status | input | 8 | Engine reply status |
| rsp_count | input | 8 | Bytes the engine received |
| res_valid | output | 1 | One-cycle result pulse |
| res_code | output | 3 | 0 ok, 1 timeout, 2 flags, 3 error, 4 too big, 5 invalid |
| res_reply | output | 4 | Reply field on success |
| res_count | output | 5 | Reported byte count |

## Verification
Byte 0 of the header is on the stream in the first cycle after the request is accepted. Each later byte follows one cycle after the previous byte is taken. A too-big or invalid request shows its result one cycle after acceptance, and a reply shows its result one cycle after the edge that samples `rsp_valid`. The bench drives inputs on falling edges and samples at the next falling edge, which is exactly where each of those registered results is due. Stalls on `tx_ready` are checked by comparing the held byte when it is finally taken.

// File: rtl/auxfmt_pkg.sv
package auxfmt_pkg;
  localparam int HDR_BYTES = 4;
  localparam int ADDR_W    = 20;
  localparam int CMD_W     = 4;

  typedef enum logic [2:0] {
    RC_OK      = 3'd0,
    RC_TIMEOUT = 3'd1,
    RC_FLAGS   = 3'd2,
    RC_IOERR   = 3'd3,
    RC_TOOBIG  = 3'd4,
    RC_INVALID = 3'd5
  } rc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } st_e;
endpackage

// File: rtl/aux_hdr_pack.sv
module aux_hdr_pack
  import auxfmt_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [CMD_W-1:0]            cmd,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [CNT_W-1:0]            len,
  input  logic                        is_write,
  output logic [HDR_BYTES-1:0][7:0]   hdr
);
  logic [CNT_W:0] total;
  logic [3:0]     size_code;
  logic [3:0]     len_code;

  always_comb begin
    total    = (CNT_W+1)'(len) + (CNT_W+1)'(HDR_BYTES);
    len_code = (len == '0) ? 4'd0 : 4'(len - CNT_W'(1));
    if (len == '0)
      size_code = 4'd3;
    else if (is_write)
      size_code = total[3:0];
    else
      size_code = 4'(HDR_BYTES);
    hdr[0] = addr[7:0];
    hdr[1] = addr[15:8];
    hdr[2] = {cmd, addr[19:16]};
    hdr[3] = {size_code, len_code};
  end
endmodule

// File: rtl/aux_reply_dec.sv
module aux_reply_dec
  import auxfmt_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [7:0]       status,
  input  logic [7:0]       rx_cnt,
  input  logic [CNT_W-1:0] len,
  input  logic             is_write,
  output logic [2:0]       code,
  output logic [3:0]       reply,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    code  = RC_OK;
    reply = 4'd0;
    count = '0;
    case (status)
      8'd1:    code = RC_TIMEOUT;
      8'd2:    code = RC_FLAGS;
      8'd3:    code = RC_IOERR;
      default: begin
        code  = RC_OK;
        reply = status[7:4];
        if (is_write)
          count = len;
        else if (rx_cnt > 8'(len))
          count = len;
        else
          count = rx_cnt[CNT_W-1:0];
      end
    endcase
  end
endmodule

// File: rtl/aux_req_fmt.sv
module aux_req_fmt
  import auxfmt_pkg::*;
#(
  parameter int MAX_LEN = 16,
  localparam int CNT_W  = $clog2(MAX_LEN + 1),
  localparam int LEN_W  = CNT_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [3:0]             req_cmd,
  input  logic [19:0]            req_addr,
  input  logic [LEN_W-1:0]       req_len,
  input  logic [MAX_LEN*8-1:0]   req_payload,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  output logic                   tx_last,
  input  logic                   rsp_valid,
  input  logic [7:0]             rsp_status,
  input  logic [7:0]             rsp_count,
  output logic                   res_valid,
  output logic [2:0]             res_code,
  output logic [3:0]             res_reply,
  output logic [CNT_W-1:0]       res_count
);
  localparam int MAXB  = MAX_LEN + HDR_BYTES;
  localparam int IDX_W = $clog2(MAXB + 1);
  localparam int PL_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  st_e                    st_q, st_d;
  logic [IDX_W-1:0]       idx_q, idx_d;
  logic [CMD_W-1:0]       cmd_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [CNT_W-1:0]       len_q;
  logic                   wr_q;
  logic [7:0]             pl_q [MAX_LEN];
  logic                   resv_q, resv_d;
  logic [2:0]             code_q, code_d;
  logic [3:0]             reply_q, reply_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;

  logic                   accept, too_big, bad_cmd, load;
  logic [IDX_W-1:0]       n_bytes;
  logic                   at_last, tx_fire;
  logic [HDR_BYTES-1:0][7:0] hdr;
  logic [PL_W-1:0]        pl_sel;
  logic [2:0]             dec_code;
  logic [3:0]             dec_reply;
  logic [CNT_W-1:0]       dec_cnt;

  aux_hdr_pack #(.CNT_W(CNT_W)) u_hdr (
    .cmd(cmd_q), .addr(addr_q), .len(len_q), .is_write(wr_q), .hdr(hdr)
  );

  aux_reply_dec #(.CNT_W(CNT_W)) u_dec (
    .status(rsp_status), .rx_cnt(rsp_count), .len(len_q), .is_write(wr_q),
    .code(dec_code), .reply(dec_reply), .count(dec_cnt)
  );

  assign req_ready = (st_q == ST_IDLE) && arst_n;
  assign accept    = req_valid && req_ready;
  assign too_big   = req_len > LEN_W'(MAX_LEN);
  assign bad_cmd   = req_cmd[1];
  assign load      = accept && !too_big && !bad_cmd;
  assign n_bytes   = wr_q ? (IDX_W'(len_q) + IDX_W'(HDR_BYTES)) : IDX_W'(HDR_BYTES);
  assign at_last   = (idx_q == n_bytes - IDX_W'(1));
  assign tx_valid  = (st_q == ST_SEND);
  assign tx_fire   = tx_valid && tx_ready;
  assign tx_last   = tx_valid && at_last;
  assign pl_sel    = PL_W'(idx_q - IDX_W'(HDR_BYTES));
  assign tx_data   = (idx_q < IDX_W'(HDR_BYTES)) ? hdr[idx_q[1:0]] : pl_q[pl_sel];

  // next-state logic
  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    resv_d  = 1'b0;
    code_d  = code_q;
    reply_d = reply_q;
    cnt_d   = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (load) begin
          st_d  = ST_SEND;
          idx_d = '0;
        end else if (accept) begin
          resv_d  = 1'b1;
          code_d  = too_big ? RC_TOOBIG : RC_INVALID;
          reply_d = 4'd0;
          cnt_d   = '0;
        end
      end
      ST_SEND: begin
        if (tx_fire) begin
          idx_d = idx_q + IDX_W'(1);
          if (at_last) st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          st_d    = ST_IDLE;
          resv_d  = 1'b1;
          code_d  = dec_code;
          reply_d = dec_reply;
          cnt_d   = dec_cnt;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      resv_q  <= 1'b0;
      code_q  <= 3'd0;
      reply_q <= 4'd0;
      cnt_q   <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      resv_q <= resv_d;
      if (resv_d) begin
        code_q  <= code_d;
        reply_q <= reply_d;
        cnt_q   <= cnt_d;
      end
    end
  end

  // request fields, clock-enabled on acceptance
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      len_q  <= '0;
      wr_q   <= 1'b0;
    end else if (load) begin
      cmd_q  <= req_cmd;
      addr_q <= req_addr;
      len_q  <= CNT_W'(req_len);
      wr_q   <= ~req_cmd[0];
    end
  end

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_pl
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)   pl_q[g] <= 8'd0;
      else if (load) pl_q[g] <= req_payload[8*g +: 8];
    end
  end

  assign res_valid = resv_q;
  assign res_code  = code_q;
  assign res_reply = reply_q;
  assign res_count = cnt_q;
endmodule

// File: rtl/aux_req_fmt_chk.sv
module aux_req_fmt_chk #(
  parameter int MAX_LEN = 16,
  localparam int CNT_W  = $clog2(MAX_LEN + 1),
  localparam int LEN_W  = CNT_W + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [3:0]           req_cmd,
  input logic [19:0]          req_addr,
  input logic [LEN_W-1:0]     req_len,
  input logic [MAX_LEN*8-1:0] req_payload,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic [7:0]           tx_data,
  input logic                 tx_last,
  input logic                 rsp_valid,
  input logic [7:0]           rsp_status,
  input logic [7:0]           rsp_count,
  input logic                 res_valid,
  input logic [2:0]           res_code,
  input logic [3:0]           res_reply,
  input logic [CNT_W-1:0]     res_count
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !req_ready);

  p_result_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> req_ready);

  p_toobig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len > LEN_W'(MAX_LEN)))
      |=> (res_valid && res_code == 3'd4 && !tx_valid));

  p_badcmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len <= LEN_W'(MAX_LEN)) && req_cmd[1])
      |=> (res_valid && res_code == 3'd5 && !tx_valid));

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len <= LEN_W'(MAX_LEN)) && !req_cmd[1])
      |=> (tx_valid && !req_ready && !res_valid));

  p_fail_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code >= 3'd1 && res_code <= 3'd3)
      |-> (res_count == '0 && res_reply == 4'd0));

  p_idle_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && req_ready && !req_valid) |=> !res_valid);
endmodule

bind aux_req_fmt aux_req_fmt_chk #(.MAX_LEN(MAX_LEN)) u_chk (.*);

// File: tb/sim_aux_req_fmt.sv
module sim_aux_req_fmt;
  localparam int MAX_LEN = 16;
  localparam int CNT_W   = 5;
  localparam int LEN_W   = 6;

  logic               clk, rst_n;
  logic               req_valid, req_ready;
  logic [3:0]         req_cmd;
  logic [19:0]        req_addr;
  logic [LEN_W-1:0]   req_len;
  logic [MAX_LEN*8-1:0] req_payload;
  logic               tx_valid, tx_ready, tx_last;
  logic [7:0]         tx_data;
  logic               rsp_valid;
  logic [7:0]         rsp_status, rsp_count;
  logic               res_valid;
  logic [2:0]         res_code;
  logic [3:0]         res_reply;
  logic [CNT_W-1:0]   res_count;

  int checks = 0;
  int failures = 0;

  aux_req_fmt #(.MAX_LEN(MAX_LEN)) u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [19:0] addr;
    logic [5:0]  len;
    logic [7:0]  st;
    logic [7:0]  rc;
    logic [2:0]  code;
  } vec_t;

  localparam vec_t VT [11] = '{
    '{4'h8, 20'hABCDE, 6'd3,  8'h00, 8'd0,  3'd0},
    '{4'h9, 20'h12345, 6'd16, 8'h20, 8'd20, 3'd0},
    '{4'h1, 20'h00050, 6'd0,  8'h10, 8'd5,  3'd0},
    '{4'h4, 20'hF0001, 6'd12, 8'h00, 8'd0,  3'd0},
    '{4'hD, 20'h0A0B0, 6'd2,  8'h01, 8'd0,  3'd1},
    '{4'h8, 20'h55AA5, 6'd16, 8'h02, 8'd0,  3'd2},
    '{4'h9, 20'h00310, 6'd4,  8'h03, 8'd4,  3'd3},
    '{4'hA, 20'h00001, 6'd1,  8'h00, 8'd0,  3'd5},
    '{4'h8, 20'h00002, 6'd17, 8'h00, 8'd0,  3'd4},
    '{4'h0, 20'h9F00E, 6'd0,  8'hA0, 8'd0,  3'd0},
    '{4'h9, 20'h77777, 6'd8,  8'h04, 8'd3,  3'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int i, input logic [19:0] a);
    return 8'(8'h5A + i * 37) ^ a[7:0];
  endfunction

  function automatic logic [7:0] exp_byte(input logic [3:0] c, input logic [19:0] a,
                                          input int len, input int i);
    logic wr;
    logic [3:0] hi, lo;
    wr = (c[1] == 1'b0) && (c[0] == 1'b0);
    lo = (len == 0) ? 4'd0 : 4'(len - 1);
    hi = (len == 0) ? 4'd3 : (wr ? 4'(4 + len) : 4'd4);
    case (i)
      0: return a[7:0];
      1: return a[15:8];
      2: return {c, a[19:16]};
      3: return {hi, lo};
      default: return pbyte(i - 4, a);
    endcase
  endfunction

  task automatic run_txn(input logic [3:0] c, input logic [19:0] a, input int len,
                         input logic [7:0] st, input logic [7:0] rc,
                         input logic [2:0] code, input bit stall);
    int nexp, k, guard, ecnt;
    logic wr;
    wr = (c[1] == 1'b0) && (c[0] == 1'b0);
    @(negedge clk);
    req_cmd = c; req_addr = a; req_len = LEN_W'(len);
    for (int i = 0; i < MAX_LEN; i++) req_payload[8*i +: 8] = pbyte(i, a);
    chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (code >= 3'd4) begin
      // R5 / R6: rejected at once, no stream byte
      chk(res_valid && res_code == code, (code == 3'd4) ? "R5 too-big result" : "R6 invalid result",
          res_code, code);
      chk(tx_valid == 1'b0, "R5 R6 no stream byte", tx_valid, 0);
      @(negedge clk);
      chk(res_valid == 1'b0 && tx_valid == 1'b0, "R9 single result pulse", res_valid, 0);
      return;
    end
    nexp = (wr && len > 0) ? 4 + len : 4;
    k = 0; guard = 0;
    while (k < nexp && guard < 200) begin
      tx_ready = stall ? guard[0] : 1'b1;
      chk(tx_valid == 1'b1 && req_ready == 1'b0, "R9 busy while sending", req_ready, 0);
      if (tx_ready) begin
        chk(tx_data == exp_byte(c, a, len, k),
            (k < 3) ? "R1 header byte" : (k == 3 ? "R2 R3 length byte" : "R4 payload byte"),
            tx_data, exp_byte(c, a, len, k));
        chk(tx_last == (k == nexp - 1), "R4 last flag", tx_last, k == nexp - 1);
        k++;
      end
      @(negedge clk);
      guard++;
    end
    tx_ready = 1'b1;
    chk(tx_valid == 1'b0 && req_ready == 1'b0, "R4 R9 stream ends and waits", tx_valid, 0);
    rsp_valid = 1'b1; rsp_status = st; rsp_count = rc;
    @(negedge clk);
    rsp_valid = 1'b0;
    if (code == 3'd0) ecnt = wr ? len : ((int'(rc) > len) ? len : int'(rc));
    else ecnt = 0;
    chk(res_valid && res_code == code, (code == 3'd0) ? "R8 success code" : "R7 error code",
        res_code, code);
    chk(res_reply == ((code == 3'd0) ? st[7:4] : 4'd0), "R8 reply field", res_reply,
        (code == 3'd0) ? st[7:4] : 4'd0);
    chk(int'(res_count) == ecnt, (code == 3'd0) ? "R8 count" : "R7 zero count", res_count, ecnt);
    chk(req_ready == 1'b1, "R9 ready with result", req_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_len = '0;
    req_payload = '0; tx_ready = 1'b1; rsp_valid = 1'b0; rsp_status = '0; rsp_count = '0;
    repeat (3) @(negedge clk);
    chk(tx_valid == 1'b0 && res_valid == 1'b0, "R11 outputs in reset", tx_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && tx_valid == 1'b0 && res_valid == 1'b0, "R11 idle after reset",
        req_ready, 1);

    foreach (VT[i])
      run_txn(VT[i].cmd, VT[i].addr, int'(VT[i].len), VT[i].st, VT[i].rc, VT[i].code, 1'b0);

    // R10: stalls on a write with payload
    run_txn(4'h8, 20'h3C3C3, 5, 8'h00, 8'd0, 3'd0, 1'b1);
    // R6: MOT bit with bit 1 set is still invalid
    run_txn(4'h6, 20'h00100, 2, 8'h00, 8'd0, 3'd5, 1'b0);
    // R5: largest length field value
    run_txn(4'h9, 20'h00200, 63, 8'h00, 8'd0, 3'd4, 1'b0);
    // R6: MOT write
    run_txn(4'hC, 20'h4B4B4, 1, 8'h30, 8'd0, 3'd0, 1'b0);

    // R12: reply status in idle is ignored
    @(negedge clk);
    rsp_valid = 1'b1; rsp_status = 8'h01; rsp_count = 8'd7;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(res_valid == 1'b0, "R12 idle reply ignored", res_valid, 0);
    chk(req_ready == 1'b1 && tx_valid == 1'b0, "R12 state unchanged", req_ready, 1);
    run_txn(4'h9, 20'h00400, 6, 8'h50, 8'd2, 3'd0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule